// File: doc/BRIEF.md
# One-Wire Thermometer Sequencer

This block reads a one-wire digital thermometer with no software involved. It sits above a bit-slot primitive. That primitive produces the line timing for one reset slot or one data slot at a time. The sequencer decides which slot comes next, what bit it writes, and what it does with the bit that comes back. A single start pulse runs one whole acquisition. The sequence resets the line and checks for presence, then reads the device's 64-bit identity and checks its family byte. Next it selects the device by that identity and starts a temperature conversion. It waits a programmable number of cycles, selects the device again, and reads the nine-byte scratchpad. The first two scratchpad bytes form the signed temperature.

All bytes go out and come in least significant bit first, one slot per bit. A read slot is a slot that writes a 1, so the device can pull the line low. Each written byte is compared with the line values sampled during its slots, which catches a shorted line or a bus clash. The block reports the identity, the temperature, a done pulse, a valid flag and a two-bit error code. The conversion wait is a cycle count, so simulation can use a short value while silicon uses about 0.8 s of clock cycles.

Top module: `ow_therm_seq`

## Requirements
- R1: While and after synchronous reset, busy, done, valid, slot_go and err_code are all 0.
- R2: A start pulse sampled while idle sets busy at that edge. The first slot request is a reset slot (slot_reset=1). A reset acknowledge with slot_rbit=1 means no device is present: the run ends with err_code=1 and no further slot is issued. A full run issues exactly three reset slots.
- R3: After presence, the block writes command 0x33 and then issues 64 read slots, each with slot_wbit=1. Received byte k (k=0..7) lands in rom_id[8k+7:8k], and bit 0 of each byte is received first.
- R4: If rom_id[7:0] is not 0x28 once all eight identity bytes are in, the run ends with err_code=2 and no further slot is issued.
- R5: Each later transaction writes 0x55 and then the eight identity bytes, rom_id[7:0] first, each byte LSB first.
- R6: The first selection is followed by command 0x44. Afterwards no slot is requested until the next reset request. That request appears WAIT_CYCLES+1 rising edges after the edge that samples the last acknowledge of the 0x44 byte.
- R7: The second selection is followed by command 0xBE and 72 read slots. temp is {byte1, byte0} of the received bytes, a two's-complement value in 1/16 degree C.
- R8: If any slot of a written byte returns a line value different from the bit written, the byte completes and the run ends with err_code=3. No further slot is issued.
- R9: done is a one-cycle pulse, and busy is 0 while done is 1. valid=1 only when err_code=0. done rises at the edge after the one that samples the final data-slot acknowledge. After a missing presence it rises at the very edge that samples the reset acknowledge.
- R10: A start pulse while busy is ignored: the run in progress keeps its slot count and issues no extra reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins one acquisition when idle |
| busy | output | 1 | High for the duration of a run |
| done | output | 1 | One-cycle pulse at the end of a run |
| valid | output | 1 | Run finished without error |
| err_code | output | 2 | 0 none, 1 no presence, 2 wrong family, 3 write mismatch |
| rom_id | output | 64 | Identity read from the device, first byte lowest |
| temp | output | 16 | Signed temperature, 1/16 degree C per LSB |
| slot_go | output | 1 | One-cycle request for a slot |
| slot_reset | output | 1 | With slot_go, the request is a reset slot |
| slot_wbit | output | 1 | Bit to write in a data slot (1 for a read) |
| slot_ack | input | 1 | One-cycle slot completion from the primitive |
| slot_rbit | input | 1 | Line value sampled in the slot (presence: 0) |

## Verification
busy is due one edge after start is sampled. done is due one edge after the edge that samples the final data-slot acknowledge, or at that same edge for a presence failure. The re-addressing reset request is due WAIT_CYCLES+1 edges after the convert byte's last acknowledge. The bench keeps a rising-edge counter and stamps every sampled acknowledge. It samples outputs only at falling edges and compares edge differences against these exact offsets. It counts slots to confirm that nothing is issued after an abort.

// File: rtl/ow_seq_pkg.sv
package ow_seq_pkg;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_NO_PRESENCE = 2'd1,
        ERR_FAMILY      = 2'd2,
        ERR_WRITE       = 2'd3
    } ow_err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET,
        ST_ROM_CMD,
        ST_ROM_DATA,
        ST_SEL_CMD,
        ST_SEL_ID,
        ST_FUNC,
        ST_CONV_WAIT,
        ST_PAD_DATA
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDENT,
        PH_CONVERT,
        PH_FETCH
    } seq_phase_e;

    localparam int BYTE_W    = 8;
    localparam int ID_BYTES  = 8;
    localparam int PAD_BYTES = 9;
    localparam int CNT_W     = $clog2(PAD_BYTES + 1);

    localparam logic [7:0] CMD_READ_ROM  = 8'h33;
    localparam logic [7:0] CMD_MATCH_ROM = 8'h55;
    localparam logic [7:0] CMD_CONVERT   = 8'h44;
    localparam logic [7:0] CMD_READ_PAD  = 8'hBE;
    localparam logic [7:0] FAMILY_TEMP   = 8'h28;
    localparam logic [7:0] READ_FILL     = 8'hFF;

    function automatic logic [7:0] byte_of(input logic [63:0] id, input logic [2:0] idx);
        logic [63:0] s;
        s = id >> {idx, 3'b000};
        return s[7:0];
    endfunction

    function automatic logic [63:0] with_byte(input logic [63:0] id, input logic [2:0] idx,
                                              input logic [7:0] b);
        logic [63:0] r;
        r = id;
        r[idx*8 +: 8] = b;
        return r;
    endfunction

endpackage

// File: rtl/ow_byte_shift.sv
module ow_byte_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  logic [BITS-1:0] tx_byte,
    input  logic            slot_ack,
    input  logic            slot_rbit,
    output logic            slot_go,
    output logic            slot_wbit,
    output logic            fin,
    output logic [BITS-1:0] rx_byte,
    output logic            mismatch
);
    localparam int IW = $clog2(BITS);

    logic            active;
    logic [IW-1:0]   idx;
    logic [BITS-1:0] tx_sh;
    logic [BITS-1:0] rx_sh;
    logic            mm_q;
    logic            go_q;
    logic            fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            mm_q   <= 1'b0;
            go_q   <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            go_q  <= 1'b0;
            fin_q <= 1'b0;
            if (launch) begin
                active <= 1'b1;
                idx    <= '0;
                tx_sh  <= tx_byte;
                mm_q   <= 1'b0;
                go_q   <= 1'b1;
            end else if (active && slot_ack) begin
                rx_sh <= {slot_rbit, rx_sh[BITS-1:1]};
                mm_q  <= mm_q | (slot_rbit != tx_sh[0]);
                tx_sh <= tx_sh >> 1;
                if (idx == IW'(BITS - 1)) begin
                    active <= 1'b0;
                    fin_q  <= 1'b1;
                end else begin
                    idx  <= idx + 1'b1;
                    go_q <= 1'b1;
                end
            end
        end
    end

    assign slot_go   = go_q;
    assign slot_wbit = tx_sh[0];
    assign fin       = fin_q;
    assign rx_byte   = rx_sh;
    assign mismatch  = mm_q;

    // R3: only one slot request at a time, never back to back
    p_single_request_r3: assert property (@(posedge clk) disable iff (rst)
        slot_go |=> !slot_go)
        else $error("slot request repeated on consecutive cycles");

endmodule

// File: rtl/ow_wait_timer.sv
module ow_wait_timer #(
    parameter int unsigned WAIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic elapsed
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(WAIT_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign elapsed = (cnt == CW'(1));

endmodule

// File: rtl/ow_therm_seq.sv
module ow_therm_seq
    import ow_seq_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 16_000_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               valid,
    output logic [1:0]         err_code,
    output logic [63:0]        rom_id,
    output logic signed [15:0] temp,
    output logic               slot_go,
    output logic               slot_reset,
    output logic               slot_wbit,
    input  logic               slot_ack,
    input  logic               slot_rbit
);
    seq_state_e        state;
    seq_phase_e        phase;
    ow_err_e           err_q;
    logic [CNT_W-1:0]  cnt;
    logic [63:0]       id_q;
    logic [15:0]       temp_q;
    logic              busy_q, done_q, valid_q;
    logic              rst_go_q;
    logic              launch_q;
    logic [7:0]        tx_q;

    logic              eng_go, eng_wbit, eng_fin, eng_mm;
    logic [7:0]        eng_rx;
    logic              wait_load, wait_elapsed;
    logic              writing;

    ow_byte_shift #(.BITS(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch_q),
        .tx_byte   (tx_q),
        .slot_ack  (slot_ack),
        .slot_rbit (slot_rbit),
        .slot_go   (eng_go),
        .slot_wbit (eng_wbit),
        .fin       (eng_fin),
        .rx_byte   (eng_rx),
        .mismatch  (eng_mm)
    );

    ow_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .load    (wait_load),
        .elapsed (wait_elapsed)
    );

    assign writing = (state == ST_ROM_CMD) || (state == ST_SEL_CMD) ||
                     (state == ST_SEL_ID)  || (state == ST_FUNC);

    assign wait_load = (state == ST_FUNC) && eng_fin && !eng_mm && (phase == PH_CONVERT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_IDENT;
            err_q    <= ERR_NONE;
            cnt      <= '0;
            id_q     <= '0;
            temp_q   <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            valid_q  <= 1'b0;
            rst_go_q <= 1'b0;
            launch_q <= 1'b0;
            tx_q     <= '0;
        end else begin
            done_q   <= 1'b0;
            rst_go_q <= 1'b0;
            launch_q <= 1'b0;
            if (writing && eng_fin && eng_mm) begin
                state   <= ST_IDLE;
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                err_q   <= ERR_WRITE;
                valid_q <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start) begin
                            busy_q   <= 1'b1;
                            valid_q  <= 1'b0;
                            err_q    <= ERR_NONE;
                            phase    <= PH_IDENT;
                            rst_go_q <= 1'b1;
                            state    <= ST_RESET;
                        end
                    end
                    ST_RESET: begin
                        if (slot_ack) begin
                            if (slot_rbit) begin
                                state   <= ST_IDLE;
                                busy_q  <= 1'b0;
                                done_q  <= 1'b1;
                                err_q   <= ERR_NO_PRESENCE;
                                valid_q <= 1'b0;
                            end else if (phase == PH_IDENT) begin
                                launch_q <= 1'b1;
                                tx_q     <= CMD_READ_ROM;
                                state    <= ST_ROM_CMD;
                            end else begin
                                launch_q <= 1'b1;
                                tx_q     <= CMD_MATCH_ROM;
                                state    <= ST_SEL_CMD;
                            end
                        end
                    end
                    ST_ROM_CMD: begin
                        if (eng_fin) begin
                            launch_q <= 1'b1;
                            tx_q     <= READ_FILL;
                            cnt      <= '0;
                            state    <= ST_ROM_DATA;
                        end
                    end
                    ST_ROM_DATA: begin
                        if (eng_fin) begin
                            id_q <= with_byte(id_q, cnt[2:0], eng_rx);
                            if (cnt == CNT_W'(ID_BYTES - 1)) begin
                                if (id_q[7:0] != FAMILY_TEMP) begin
                                    state   <= ST_IDLE;
                                    busy_q  <= 1'b0;
                                    done_q  <= 1'b1;
                                    err_q   <= ERR_FAMILY;
                                    valid_q <= 1'b0;
                                end else begin
                                    phase    <= PH_CONVERT;
                                    rst_go_q <= 1'b1;
                                    state    <= ST_RESET;
                                end
                            end else begin
                                cnt      <= cnt + 1'b1;
                                launch_q <= 1'b1;
                                tx_q     <= READ_FILL;
                            end
                        end
                    end
                    ST_SEL_CMD: begin
                        if (eng_fin) begin
                            launch_q <= 1'b1;
                            tx_q     <= byte_of(id_q, 3'd0);
                            cnt      <= '0;
                            state    <= ST_SEL_ID;
                        end
                    end
                    ST_SEL_ID: begin
                        if (eng_fin) begin
                            launch_q <= 1'b1;
                            if (cnt == CNT_W'(ID_BYTES - 1)) begin
                                tx_q  <= (phase == PH_CONVERT) ? CMD_CONVERT : CMD_READ_PAD;
                                state <= ST_FUNC;
                            end else begin
                                cnt  <= cnt + 1'b1;
                                tx_q <= byte_of(id_q, cnt[2:0] + 3'd1);
                            end
                        end
                    end
                    ST_FUNC: begin
                        if (eng_fin) begin
                            if (phase == PH_CONVERT) begin
                                state <= ST_CONV_WAIT;
                            end else begin
                                launch_q <= 1'b1;
                                tx_q     <= READ_FILL;
                                cnt      <= '0;
                                state    <= ST_PAD_DATA;
                            end
                        end
                    end
                    ST_CONV_WAIT: begin
                        if (wait_elapsed) begin
                            phase    <= PH_FETCH;
                            rst_go_q <= 1'b1;
                            state    <= ST_RESET;
                        end
                    end
                    ST_PAD_DATA: begin
                        if (eng_fin) begin
                            if (cnt == CNT_W'(0)) temp_q[7:0]  <= eng_rx;
                            if (cnt == CNT_W'(1)) temp_q[15:8] <= eng_rx;
                            if (cnt == CNT_W'(PAD_BYTES - 1)) begin
                                state   <= ST_IDLE;
                                busy_q  <= 1'b0;
                                done_q  <= 1'b1;
                                err_q   <= ERR_NONE;
                                valid_q <= 1'b1;
                            end else begin
                                cnt      <= cnt + 1'b1;
                                launch_q <= 1'b1;
                                tx_q     <= READ_FILL;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign valid      = valid_q;
    assign err_code   = err_q;
    assign rom_id     = id_q;
    assign temp       = temp_q;
    assign slot_go    = eng_go | rst_go_q;
    assign slot_reset = rst_go_q;
    assign slot_wbit  = rst_go_q | eng_wbit;

    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done held for more than one cycle");

    // R9: the run is over when done is reported
    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy)
        else $error("busy still high with done");

    // R9: an error code never comes with valid
    p_err_blocks_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (err_code != 2'd0) |-> !valid)
        else $error("valid set alongside an error");

    // R6: the line stays untouched during the conversion wait
    p_quiet_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV_WAIT) |-> !slot_go)
        else $error("slot requested during conversion wait");

    // R2: reset and data slot requests never collide
    p_reset_alone_r2: assert property (@(posedge clk) disable iff (rst)
        rst_go_q |-> !eng_go)
        else $error("reset slot and data slot requested together");

endmodule

// File: tb/ow_therm_seq_tb.sv
module ow_therm_seq_tb;

    localparam int WAIT = 150;
    localparam int M_CMD = 0, M_ROM = 1, M_MATCH = 2, M_FCMD = 3, M_PAD = 4, M_IDLE = 5;
    localparam int SLOTS_FULL = 307;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic slot_ack = 1'b0;
    logic slot_rbit = 1'b1;
    logic busy, done, valid, slot_go, slot_reset, slot_wbit;
    logic [1:0] err_code;
    logic [63:0] rom_id;
    logic signed [15:0] temp;

    ow_therm_seq #(.WAIT_CYCLES(WAIT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .valid(valid),
        .err_code(err_code), .rom_id(rom_id), .temp(temp), .slot_go(slot_go),
        .slot_reset(slot_reset), .slot_wbit(slot_wbit), .slot_ack(slot_ack),
        .slot_rbit(slot_rbit)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_ack = 0;
    int conv_ack = -1;
    int gap = -1;
    bit conv_mark = 0;
    bit conv_pend = 0;

    logic [63:0] s_id;
    logic [71:0] s_pad;
    bit          s_present;
    int          s_inj;
    int          mode, bc;
    logic [7:0]  cmd;
    bit          match_ok;
    int n_slots, n_nr, n_resets, n_rom, n_match, n_conv, n_pad, n_badread;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (slot_ack) begin
            last_ack = cyc;
            if (conv_mark) begin
                conv_ack  = cyc;
                conv_mark = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic serve(input bit is_rst, input bit wb, output logic r);
        int idx;
        if (is_rst) begin
            n_resets++;
            r = s_present ? 1'b0 : 1'b1;
            mode = M_CMD;
            bc = 0;
            cmd = '0;
            if (conv_pend) begin
                gap = cyc - conv_ack;
                conv_pend = 0;
            end
            return;
        end
        idx = n_nr;
        n_nr++;
        r = wb;
        case (mode)
            M_CMD: begin
                cmd[bc] = wb;
                bc++;
                if (bc == 8) begin
                    bc = 0;
                    if (cmd == 8'h33) begin mode = M_ROM; n_rom++; end
                    else if (cmd == 8'h55) begin mode = M_MATCH; match_ok = 1; end
                    else mode = M_IDLE;
                end
            end
            M_ROM: begin
                r = wb & s_id[bc];
                if (!wb) n_badread++;
                bc++;
                if (bc == 64) begin bc = 0; mode = M_IDLE; end
            end
            M_MATCH: begin
                if (wb != s_id[bc]) match_ok = 0;
                bc++;
                if (bc == 64) begin
                    bc = 0;
                    mode = M_FCMD;
                    cmd = '0;
                    if (match_ok) n_match++;
                end
            end
            M_FCMD: begin
                cmd[bc] = wb;
                bc++;
                if (bc == 8) begin
                    bc = 0;
                    mode = M_IDLE;
                    if (match_ok && cmd == 8'h44) begin
                        n_conv++;
                        conv_mark = 1;
                        conv_pend = 1;
                    end
                    if (match_ok && cmd == 8'hBE) begin
                        mode = M_PAD;
                        n_pad++;
                    end
                end
            end
            M_PAD: begin
                r = wb & s_pad[bc];
                if (!wb) n_badread++;
                bc++;
                if (bc == 72) begin bc = 0; mode = M_IDLE; end
            end
            default: r = wb;
        endcase
        if (idx == s_inj) r = 1'b0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (slot_ack) begin
                slot_ack  = 1'b0;
                slot_rbit = 1'b1;
            end
            if (slot_go && !rst) begin
                logic r;
                n_slots++;
                serve(slot_reset, slot_wbit, r);
                @(negedge clk);
                slot_rbit = r;
                slot_ack  = 1'b1;
            end
        end
    end

    task automatic run_case(input logic [63:0] id, input logic [15:0] t, input bit present,
                            input int inj, input int exp_err, input int exp_slots,
                            input bit restart, input string tag);
        int w;
        int diff;
        s_id      = id;
        s_pad     = {8'hA5, 8'h10, 8'h0C, 8'hFF, 8'h7F, 8'h46, 8'h4B, t[15:8], t[7:0]};
        s_present = present;
        s_inj     = inj;
        n_slots = 0; n_nr = 0; n_resets = 0; n_rom = 0; n_match = 0;
        n_conv = 0; n_pad = 0; n_badread = 0;
        mode = M_IDLE; bc = 0; gap = -1; conv_pend = 0; conv_mark = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R2 busy after start ", tag}, busy, 1);
        w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            start = (restart && w == 300);
            w++;
        end
        start = 1'b0;
        if (!done) begin
            chk(1'b0, {"R9 watchdog waiting for done ", tag}, 0, 1);
            return;
        end
        diff = cyc - last_ack;
        chk(busy == 1'b0, {"R9 busy low at done ", tag}, busy, 0);
        chk(err_code == 2'(exp_err), {"R2/R4/R8 error code ", tag}, err_code, exp_err);
        chk(valid == (exp_err == 0), {"R9 valid ", tag}, valid, exp_err == 0);
        chk(diff == ((exp_err == 1) ? 0 : 1), {"R9 done timing ", tag}, diff, (exp_err == 1) ? 0 : 1);
        if (exp_err == 0) begin
            chk(rom_id == id, {"R3 identity ", tag}, rom_id, id);
            chk(temp == $signed(t), {"R7 temperature ", tag}, temp, t);
            chk(n_match == 2, {"R5 selections matched ", tag}, n_match, 2);
            chk(n_conv == 1, {"R6 convert issued ", tag}, n_conv, 1);
            chk(gap == WAIT + 1, {"R6 wait length ", tag}, gap, WAIT + 1);
            chk(n_pad == 1, {"R7 scratchpad read ", tag}, n_pad, 1);
            chk(n_badread == 0, {"R3 read slots write 1 ", tag}, n_badread, 0);
            chk(n_resets == 3, {"R2 reset count ", tag}, n_resets, 3);
        end
        if (exp_err == 2) chk(rom_id == id, {"R3 identity on family error ", tag}, rom_id, id);
        @(negedge clk);
        chk(done == 1'b0, {"R9 done one cycle ", tag}, done, 0);
        repeat (10) @(negedge clk);
        chk(n_slots == exp_slots, {"R2/R4/R8/R10 slot total ", tag}, n_slots, exp_slots);
        if (restart) chk(n_rom == 1 && n_resets == 3, {"R10 start ignored ", tag}, n_rom, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(busy == 0 && done == 0 && valid == 0 && slot_go == 0 && err_code == 0,
            "R1 reset state", {busy, done, valid, slot_go, err_code}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 0 && slot_go == 0, "R1 idle after reset", {busy, slot_go}, 0);

        for (int i = 0; i < 8; i++) begin
            logic [63:0] id;
            logic [15:0] t;
            id = {8'(8'hC0 ^ i), 48'(48'h1234_5678_9ABC * (i + 1)), 8'h28};
            t  = 16'((i * 16'h0391) ^ ((i % 2 == 1) ? 16'hF000 : 16'h0000));
            run_case(id, t, 1'b1, -1, 0, SLOTS_FULL, 1'b0, $sformatf("sweep%0d", i));
        end

        run_case(64'h5A00_0000_0000_0128, 16'h0191, 1'b0, -1, 1, 1, 1'b0, "absent");
        run_case(64'h5A00_0000_0000_0110, 16'h0191, 1'b1, -1, 2, 73, 1'b0, "family");
        run_case(64'h5A00_0000_0000_0128, 16'h0191, 1'b1, 0, 3, 9, 1'b0, "romcmd-clash");

        for (int b = 0; b < 8; b++) begin
            bit fails;
            fails = ((8'h55 >> b) & 8'h01) != 0;
            run_case(64'h77EE_0102_0304_0528, 16'hFF5E, 1'b1, 72 + b,
                     fails ? 3 : 0, fails ? 82 : SLOTS_FULL, 1'b0, $sformatf("R8 clash bit%0d", b));
        end

        run_case(64'h3300_AABB_CCDD_EE28, 16'hFC90, 1'b1, -1, 0, SLOTS_FULL, 1'b1, "restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule